// File: doc/BRIEF.md
# Miss Tracking Table with Late-Prefetch Counting

This block keeps a small table of outstanding cache-line misses. Every entry holds a pending line address, an occupancy flag and a flag recording whether the miss was started by a software prefetch. A lookup request carries a line address and a prefetch flag. The block compares that address against all occupied entries in one step. If an entry matches, the request is reported as merged. If nothing matches and an entry is free, the request takes the lowest-numbered free entry. A release port frees an entry when memory answers the miss.

The block also measures prefetch timeliness. A demand request (prefetch flag low) that finds its line still pending under a prefetch is a late prefetch. Each such request is flagged in the response and adds one to a saturating counter. Responses are registered and appear one clock after the request.

Top module: `mshr_pf_tracker`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, there is no occupied entry: `full` is 0, `rsp_valid` is 0 and `late_count` is 0.
- R2: The cycle after a request, `rsp_valid` is 1 and `rsp_match` bit i is 1 exactly when entry i was occupied with the requested address. The comparison uses the table as it stood before that clock edge.
- R3: A request that matches no entry, arriving while an entry is free, takes the lowest-index free entry. The response then shows `rsp_alloc`=1 and `rsp_idx` set to that index.
- R4: `full` is 1 exactly when every entry is occupied. A non-matching request while full gives `rsp_alloc`=0 and `rsp_merged`=0, and it changes no entry.
- R5: A request that matches an entry gives `rsp_merged`=1 and `rsp_idx` set to the matching entry. It takes no new entry, and no two occupied entries ever hold the same address.
- R6: On allocation the entry's prefetch flag is written from `req_pf`. Later lookups use that stored value.
- R7: A request with `req_pf`=0 that matches an entry whose stored prefetch flag is 1 gives `rsp_late`=1. `late_count` goes up by one on the same edge. In all other cases the counter holds.
- R8: A prefetch request that matches any entry, or a demand request that matches a demand entry, gives `rsp_late`=0.
- R9: `rel_valid` with `rel_idx` frees that entry. Later requests to its address no longer match, and the entry can be taken again.
- R10: `late_count` saturates at its all-ones value.
- R11: A request in the same cycle as a release of its matching entry still sees the entry. It is counted as late if the entry's prefetch flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup/allocate request strobe |
| req_addr | input | ADDR_W | Line address of the request |
| req_pf | input | 1 | Request is a software prefetch |
| rel_valid | input | 1 | Release strobe |
| rel_idx | input | IDX_W | Entry index to free |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_match | output | ENTRIES | Per-entry address match vector |
| rsp_merged | output | 1 | Request hit a pending entry |
| rsp_alloc | output | 1 | Request took a new entry |
| rsp_idx | output | IDX_W | Allocated or matched entry, else 0 |
| rsp_late | output | 1 | Demand request hit a pending prefetch |
| full | output | 1 | All entries occupied |
| late_count | output | CNT_W | Saturating late-prefetch count |

## Verification
The assertions take for granted that `req_addr` and `req_pf` are known whenever `req_valid` is high. They also assume that `rel_idx` names an entry below ENTRIES whenever `rel_valid` is high. The uniqueness and allocation properties depend on the allocator taking only free entries. For that reason the stimulus never releases an entry in the same cycle it is being taken. It releases only entries that the reference model knows are occupied. A second instance with a 2-bit counter receives the same stimulus, so saturation can be reached within a short run.

// File: rtl/mshr_pf_pkg.sv
package mshr_pf_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_ADDR_W  = 26;
  localparam int unsigned DEF_CNT_W   = 32;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mshr_entry_table.sv
module mshr_entry_table #(
  parameter int unsigned ENTRIES = mshr_pf_pkg::DEF_ENTRIES,
  parameter int unsigned ADDR_W  = mshr_pf_pkg::DEF_ADDR_W,
  localparam int unsigned IDX_W  = mshr_pf_pkg::idx_width(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           alloc_en,
  input  logic [IDX_W-1:0]               alloc_idx,
  input  logic [ADDR_W-1:0]              alloc_addr,
  input  logic                           alloc_pf,
  input  logic                           free_en,
  input  logic [IDX_W-1:0]               free_idx,
  output logic [ENTRIES-1:0]             busy_vec,
  output logic [ENTRIES-1:0]             pf_vec,
  output logic [ENTRIES-1:0][ADDR_W-1:0] addr_vec
);
  logic [ENTRIES-1:0] busy_q;
  logic [ADDR_W-1:0]  addr_mem [ENTRIES];
  logic               pf_mem   [ENTRIES];

  // occupancy flags carry reset
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
    end else begin
      if (free_en)  busy_q[free_idx]  <= 1'b0;
      if (alloc_en) busy_q[alloc_idx] <= 1'b1;
    end
  end

  // address and prefetch tables: plain write port, no reset
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      addr_mem[alloc_idx] <= alloc_addr;
      pf_mem[alloc_idx]   <= alloc_pf;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_out
    assign addr_vec[g] = addr_mem[g];
    assign pf_vec[g]   = pf_mem[g];
  end
  assign busy_vec = busy_q;

  AST_ALLOC_FREE_ONLY: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !busy_q[alloc_idx]); // R3
  AST_ALLOC_FREE_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && free_en) |-> (alloc_idx != free_idx)); // R9
endmodule

// File: rtl/mshr_match_unit.sv
module mshr_match_unit #(
  parameter int unsigned ENTRIES = mshr_pf_pkg::DEF_ENTRIES,
  parameter int unsigned ADDR_W  = mshr_pf_pkg::DEF_ADDR_W,
  localparam int unsigned IDX_W  = mshr_pf_pkg::idx_width(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              look_addr,
  input  logic [ENTRIES-1:0]             busy_vec,
  input  logic [ENTRIES-1:0]             pf_vec,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] addr_vec,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic                           hit_any,
  output logic                           hit_pf,
  output logic [IDX_W-1:0]               hit_idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = busy_vec[g] && (addr_vec[g] == look_addr);
  end

  assign hit_any = |hit_vec;
  assign hit_pf  = |(hit_vec & pf_vec);

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R5
endmodule

// File: rtl/mshr_free_pick.sv
module mshr_free_pick #(
  parameter int unsigned ENTRIES = mshr_pf_pkg::DEF_ENTRIES,
  localparam int unsigned IDX_W  = mshr_pf_pkg::idx_width(ENTRIES)
) (
  input  logic [ENTRIES-1:0] busy_vec,
  output logic               free_any,
  output logic [IDX_W-1:0]   free_idx
);
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy_vec[i]) free_idx = IDX_W'(i);
    end
  end
  assign free_any = ~&busy_vec;
endmodule

// File: rtl/mshr_sat_counter.sv
module mshr_sat_counter #(
  parameter int unsigned CNT_W = mshr_pf_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (bump && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end
  assign value = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOP) |=> (cnt_q == TOP)); // R10
  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bump |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/mshr_pf_tracker.sv
module mshr_pf_tracker #(
  parameter int unsigned ENTRIES = mshr_pf_pkg::DEF_ENTRIES,
  parameter int unsigned ADDR_W  = mshr_pf_pkg::DEF_ADDR_W,
  parameter int unsigned CNT_W   = mshr_pf_pkg::DEF_CNT_W,
  localparam int unsigned IDX_W  = mshr_pf_pkg::idx_width(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_pf,
  input  logic               rel_valid,
  input  logic [IDX_W-1:0]   rel_idx,
  output logic               rsp_valid,
  output logic [ENTRIES-1:0] rsp_match,
  output logic               rsp_merged,
  output logic               rsp_alloc,
  output logic [IDX_W-1:0]   rsp_idx,
  output logic               rsp_late,
  output logic               full,
  output logic [CNT_W-1:0]   late_count
);
  logic [ENTRIES-1:0]             busy_vec, pf_vec, hit_vec;
  logic [ENTRIES-1:0][ADDR_W-1:0] addr_vec;
  logic                           hit_any, hit_pf, free_any;
  logic [IDX_W-1:0]               hit_idx, free_idx;
  logic                           take_entry, is_late, rel_ok;

  assign rel_ok     = rel_valid && ({1'b0, rel_idx} < (IDX_W+1)'(ENTRIES));
  assign take_entry = req_valid && !hit_any && free_any;
  assign is_late    = req_valid && !req_pf && hit_pf;

  mshr_entry_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst(rst),
    .alloc_en(take_entry), .alloc_idx(free_idx),
    .alloc_addr(req_addr), .alloc_pf(req_pf),
    .free_en(rel_ok), .free_idx(rel_idx),
    .busy_vec(busy_vec), .pf_vec(pf_vec), .addr_vec(addr_vec)
  );

  mshr_match_unit #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst), .look_addr(req_addr),
    .busy_vec(busy_vec), .pf_vec(pf_vec), .addr_vec(addr_vec),
    .hit_vec(hit_vec), .hit_any(hit_any), .hit_pf(hit_pf), .hit_idx(hit_idx)
  );

  mshr_free_pick #(.ENTRIES(ENTRIES)) u_pick (
    .busy_vec(busy_vec), .free_any(free_any), .free_idx(free_idx)
  );

  mshr_sat_counter #(.CNT_W(CNT_W)) u_late_cnt (
    .clk(clk), .rst(rst), .bump(is_late), .value(late_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_match  <= '0;
      rsp_merged <= 1'b0;
      rsp_alloc  <= 1'b0;
      rsp_idx    <= '0;
      rsp_late   <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_match  <= req_valid ? hit_vec : '0;
      rsp_merged <= req_valid && hit_any;
      rsp_alloc  <= take_entry;
      rsp_idx    <= take_entry ? free_idx : (req_valid && hit_any) ? hit_idx : '0;
      rsp_late   <= is_late;
    end
  end

  assign full = !free_any;

  AST_MERGE_EXCLUDES_ALLOC: assert property (@(posedge clk) disable iff (rst)
    !(rsp_merged && rsp_alloc)); // R5
  AST_LATE_NEEDS_MERGE: assert property (@(posedge clk) disable iff (rst)
    rsp_late |-> rsp_merged); // R7
  AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (full && req_valid) |=> !rsp_alloc); // R4
  AST_RSP_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_late)); // R2
endmodule

// File: tb/test_mshr_pf_tracker.sv
module test_mshr_pf_tracker;
  localparam int N = 8;
  localparam int AW = 26;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_pf = 1'b0, rel_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [IW-1:0] rel_idx = '0;

  logic rsp_valid, rsp_merged, rsp_alloc, rsp_late, full;
  logic [N-1:0] rsp_match;
  logic [IW-1:0] rsp_idx;
  logic [31:0] late_count;

  logic s_valid, s_merged, s_alloc, s_late, s_full;
  logic [N-1:0] s_match;
  logic [IW-1:0] s_idx;
  logic [1:0] s_count;

  always #2 clk = ~clk;

  mshr_pf_tracker i_mshr_pf_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_pf(req_pf),
    .rel_valid(rel_valid), .rel_idx(rel_idx), .rsp_valid(rsp_valid), .rsp_match(rsp_match),
    .rsp_merged(rsp_merged), .rsp_alloc(rsp_alloc), .rsp_idx(rsp_idx), .rsp_late(rsp_late),
    .full(full), .late_count(late_count)
  );

  mshr_pf_tracker #(.CNT_W(2)) i_mshr_pf_tracker_sat (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_pf(req_pf),
    .rel_valid(rel_valid), .rel_idx(rel_idx), .rsp_valid(s_valid), .rsp_match(s_match),
    .rsp_merged(s_merged), .rsp_alloc(s_alloc), .rsp_idx(s_idx), .rsp_late(s_late),
    .full(s_full), .late_count(s_count)
  );

  typedef struct {
    logic [N-1:0]  match;
    logic          merged;
    logic          alloc;
    logic [IW-1:0] idx;
    logic          late;
    logic          full;
    logic [31:0]   cnt;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic          m_busy [N];
  logic [AW-1:0] m_addr [N];
  logic          m_pf   [N];
  logic [31:0]   m_late = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input logic pf, input logic rel, input int ri);
    exp_t e;
    int fi;
    bit found;
    @(negedge clk);
    e = '{match: '0, merged: 1'b0, alloc: 1'b0, idx: '0, late: 1'b0, full: 1'b0, cnt: '0};
    fi = 0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (m_busy[i] && m_addr[i] == a) begin
        e.match[i] = 1'b1;
        e.merged = 1'b1;
        e.idx = IW'(i);
        if (m_pf[i] && !pf) e.late = 1'b1;
      end
    end
    if (!e.merged) begin
      for (int i = 0; i < N; i++) begin
        if (!found && !m_busy[i]) begin
          found = 1'b1;
          fi = i;
        end
      end
      if (found) begin
        e.alloc = 1'b1;
        e.idx = IW'(fi);
      end
    end
    if (e.late && m_late != 32'hFFFF_FFFF) m_late++;
    if (rel) m_busy[ri] = 1'b0;
    if (e.alloc) begin
      m_busy[fi] = 1'b1;
      m_addr[fi] = a;
      m_pf[fi] = pf;
    end
    e.full = 1'b1;
    for (int i = 0; i < N; i++) if (!m_busy[i]) e.full = 1'b0;
    e.cnt = m_late;
    req_valid = 1'b1;
    req_addr = a;
    req_pf = pf;
    rel_valid = rel;
    rel_idx = IW'(ri);
    exp_q.push_back(e);
  endtask

  task automatic release_only(input int ri);
    @(negedge clk);
    req_valid = 1'b0;
    rel_valid = 1'b1;
    rel_idx = IW'(ri);
    m_busy[ri] = 1'b0;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    rel_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: pops one expected item per response
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (!rst && rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected response", 32'(rsp_valid), 32'd0);
        end else begin
          e = exp_q.pop_front();
          check(rsp_match == e.match, "R2 match vector", 32'(rsp_match), 32'(e.match));
          check(rsp_merged == e.merged, "R5 merged", 32'(rsp_merged), 32'(e.merged));
          check(rsp_alloc == e.alloc, "R3 alloc", 32'(rsp_alloc), 32'(e.alloc));
          check(rsp_idx == e.idx, "R3 index", 32'(rsp_idx), 32'(e.idx));
          check(rsp_late == e.late, "R7 late flag", 32'(rsp_late), 32'(e.late));
          check(full == e.full, "R4 full", 32'(full), 32'(e.full));
          check(late_count == e.cnt, "R7 late count", late_count, e.cnt);
          check(32'(s_count) == ((e.cnt > 3) ? 32'd3 : e.cnt), "R10 saturation",
                32'(s_count), (e.cnt > 3) ? 32'd3 : e.cnt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 1'b0;
      m_addr[i] = '0;
      m_pf[i] = 1'b0;
    end
    repeat (2) @(negedge clk);
    check(full == 1'b0 && rsp_valid == 1'b0, "R1 reset state", {30'd0, full, rsp_valid}, 32'd0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(full == 1'b0, "R1 full after reset", 32'(full), 32'd0);
    check(late_count == 32'd0, "R1 count after reset", late_count, 32'd0);
    check(rsp_valid == 1'b0, "R1 no response", 32'(rsp_valid), 32'd0);

    send(26'h00A0, 1'b1, 1'b0, 0);  // R6 prefetch entry 0
    send(26'h00B0, 1'b0, 1'b0, 0);  // R3 demand entry 1
    send(26'h00A0, 1'b0, 1'b0, 0);  // R7 late
    send(26'h00A0, 1'b1, 1'b0, 0);  // R8 prefetch on prefetch
    send(26'h00B0, 1'b0, 1'b0, 0);  // R8 demand on demand
    send(26'h00B0, 1'b1, 1'b0, 0);  // R8 prefetch on demand
    send(26'h00A0, 1'b0, 1'b1, 0);  // R11 release same cycle, still late
    send(26'h00A0, 1'b0, 1'b0, 0);  // R9 no match, reuses entry 0
    send(26'h00A0, 1'b0, 1'b0, 0);  // R6 stored demand flag, not late
    for (int k = 0; k < 6; k++) send(26'h0C00 + AW'(k), 1'b1, 1'b0, 0); // fill
    idle(1);
    check(full == 1'b1, "R4 full when all busy", 32'(full), 32'd1);
    send(26'h3FF0, 1'b0, 1'b0, 0);  // R4 ignored while full
    send(26'h0C00, 1'b0, 1'b0, 0);  // R7 late on entry 2
    send(26'h0C00, 1'b0, 1'b0, 0);
    send(26'h0C00, 1'b0, 1'b0, 0);  // R10 small counter saturates
    release_only(3);
    send(26'h1234, 1'b0, 1'b0, 0);  // R9 freed entry 3 reused
    send(26'h0C01, 1'b0, 1'b0, 0);  // R9 released address no longer matches
    idle(4);
    check(exp_q.size() == 0, "R2 all responses seen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule